// File: doc/BRIEF.md
# Register-Mapped Multiply/Divide Unit

This block gives a move-only processor integer multiply and divide without any opcodes. It sits next to the processor's accumulator and exposes three registers on the processor's register address space. A move that stores a value into the multiply register starts an unsigned 16 x 16 multiply against the current accumulator. A move into the divide register starts an unsigned divide of the accumulator by the stored value. Each operation runs one result bit per clock. When it finishes, the unit hands a new accumulator value back through a load strobe and keeps the other half of the result in the register that was written.

A third register holds the entry address of a divide-by-zero handler. While that register is zero, dividing by zero fails quietly: the accumulator becomes zero and the old accumulator is parked in the divide register. Once software loads a nonzero handler address, a zero divisor instead raises a one-cycle trap request carrying that address to the program-counter logic, and no result is written.

The processor may keep issuing other moves while the unit is busy. A busy flag tells software when results are ready.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, reads of all four register addresses return zero, and busy, trapReq and accWe are low.
- R2: A write of value M to address 0 (multiply) while idle multiplies M by the accumulator sampled at that write, as unsigned numbers. The low 16 bits of the 32-bit product appear on accOut with accWe high. The high 16 bits are then readable at address 0.
- R3: A write of a nonzero divisor D to address 1 (divide) while idle divides the sampled accumulator by D, unsigned. The quotient appears on accOut with accWe high. The remainder, always less than D, is then readable at address 1.
- R4: A write to address 2 stores a handler address, readable at address 2. This write takes effect even while busy and does not disturb a running operation.
- R5: A divide by zero while the handler register is zero drives accOut to zero with accWe high in the first cycle after the write. The old accumulator becomes readable at address 1. Busy is high for that single cycle only.
- R6: For a multiply or a nonzero divide, busy rises in the cycle after the start write. accWe is high in exactly the 17th busy cycle, and busy falls in the cycle after that. Changes on accIn after the start write have no effect.
- R7: Writes to address 0 or 1 while busy are ignored: the result and both register values are those of the operation already running.
- R8: A divide by zero while the handler register is nonzero raises trapReq for exactly one cycle, the cycle after the write, with trapAddr equal to the handler register. Busy stays low, accWe stays low, and the value at address 1 is unchanged.
- R9: Reads of address 3 return zero, and writes to address 3 change no register and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address: 0 multiply, 1 divide, 2 handler, 3 unused |
| wrData | input | 16 | Write data (operand or handler address) |
| rdAddr | input | 2 | Read register address, same encoding |
| rdData | output | 16 | Combinational read data |
| accIn | input | 16 | Current accumulator value, sampled on a start write |
| accOut | output | 16 | New accumulator value, valid while accWe is high |
| accWe | output | 1 | One-cycle accumulator load strobe |
| busy | output | 1 | An operation is in progress |
| trapReq | output | 1 | One-cycle request to call the divide-by-zero handler |
| trapAddr | output | 16 | Handler address accompanying trapReq |

## Verification
The assertions assume that reset is applied before any write. They also assume that the divisor register input stays fixed for the whole run of a divide, which is what makes the remainder bound hold after every step. The assertions take for granted that only the processor drives the write port, one register per cycle, so a handler write and a start write never share a cycle. The stimulus drives at most one write per cycle and places every deliberate write during busy (an ignored start or a handler update) strictly inside a running multi-cycle operation. Quiet zero divides are issued only while the handler register is zero, and trap cases only after a nonzero handler is loaded.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    REG_MUL     = 2'd0,
    REG_DIV     = 2'd1,
    REG_HANDLER = 2'd2,
    REG_NONE    = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_DONE
  } mduState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadMul;
    logic loadDiv;
    logic loadZero;
    logic stepMul;
    logic stepDiv;
    logic commitMul;
    logic commitDiv;
  } mduStrobes_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic        divisorZero,
  input  logic        handlerZero,
  output mduStrobes_t strobes,
  output logic        busy,
  output logic        trapReq
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  mduState_e        state;
  logic [CNT_W-1:0] stepCnt;
  logic             doneIsDiv;
  logic             startMul;
  logic             startDiv;
  logic             trapStart;

  always_comb begin
    startMul  = wrEn && (wrAddr == REG_MUL) && (state == ST_IDLE);
    startDiv  = wrEn && (wrAddr == REG_DIV) && (state == ST_IDLE);
    trapStart = startDiv && divisorZero && !handlerZero;

    strobes           = '0;
    strobes.loadMul   = startMul;
    strobes.loadDiv   = startDiv && !divisorZero;
    strobes.loadZero  = startDiv && divisorZero && handlerZero;
    strobes.stepMul   = (state == ST_MUL);
    strobes.stepDiv   = (state == ST_DIV);
    strobes.commitMul = (state == ST_DONE) && !doneIsDiv;
    strobes.commitDiv = (state == ST_DONE) && doneIsDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepCnt   <= '0;
      doneIsDiv <= 1'b0;
      trapReq   <= 1'b0;
    end else begin
      trapReq <= trapStart;
      unique case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (strobes.loadMul) begin
            state     <= ST_MUL;
            doneIsDiv <= 1'b0;
          end else if (strobes.loadDiv) begin
            state     <= ST_DIV;
            doneIsDiv <= 1'b1;
          end else if (strobes.loadZero) begin
            state     <= ST_DONE;
            doneIsDiv <= 1'b1;
          end
        end
        ST_MUL, ST_DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // Busy-cycle counter used only by the checks below
  logic [CNT_W:0] busyCycles;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCycles <= '0;
    else if (busy) busyCycles <= busyCycles + 1'b1;
    else           busyCycles <= '0;
  end

  assert_commit_ends_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitMul || strobes.commitDiv) |=> !busy);

  assert_run_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitMul || strobes.commitDiv) |->
      (busyCycles == (CNT_W+1)'(WIDTH) || busyCycles == '0));

  assert_trap_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> !trapReq);

  assert_trap_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> !busy);

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduStrobes_t      strobes,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] accIn,
  input  logic [1:0]       rdAddr,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] accOut,
  output logic             accWe,
  output logic             handlerZero,
  output logic [WIDTH-1:0] trapAddr
);

  logic [WIDTH:0]   hiReg;     // running upper half / partial remainder
  logic [WIDTH-1:0] loReg;     // multiplier bits / dividend-quotient bits
  logic [WIDTH-1:0] operand;   // multiplicand or divisor
  logic [WIDTH-1:0] mulReg;
  logic [WIDTH-1:0] divReg;
  logic [WIDTH-1:0] handlerReg;

  // Shift-and-add step
  logic [WIDTH:0] addend;
  logic [WIDTH:0] mulSum;
  // Restoring divide step
  logic [WIDTH:0] shifted;
  logic [WIDTH:0] diff;
  logic           fits;

  always_comb begin
    addend  = loReg[0] ? {1'b0, operand} : '0;
    mulSum  = {1'b0, hiReg[WIDTH-1:0]} + addend;
    shifted = {hiReg[WIDTH-1:0], loReg[WIDTH-1]};
    fits    = (shifted >= {1'b0, operand});
    diff    = shifted - {1'b0, operand};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg   <= '0;
      loReg   <= '0;
      operand <= '0;
    end else if (strobes.loadMul || strobes.loadDiv) begin
      hiReg   <= '0;
      loReg   <= accIn;
      operand <= wrData;
    end else if (strobes.loadZero) begin
      hiReg   <= {1'b0, accIn};
      loReg   <= '0;
    end else if (strobes.stepMul) begin
      hiReg   <= {1'b0, mulSum[WIDTH:1]};
      loReg   <= {mulSum[0], loReg[WIDTH-1:1]};
    end else if (strobes.stepDiv) begin
      hiReg   <= fits ? diff : shifted;
      loReg   <= {loReg[WIDTH-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulReg     <= '0;
      divReg     <= '0;
      handlerReg <= '0;
    end else begin
      if (strobes.commitMul) mulReg <= hiReg[WIDTH-1:0];
      if (strobes.commitDiv) divReg <= hiReg[WIDTH-1:0];
      if (wrEn && wrAddr == REG_HANDLER) handlerReg <= wrData;
    end
  end

  always_comb begin
    unique case (rdAddr)
      REG_MUL:     rdData = mulReg;
      REG_DIV:     rdData = divReg;
      REG_HANDLER: rdData = handlerReg;
      default:     rdData = '0;
    endcase
  end

  assign accOut      = loReg;
  assign accWe       = strobes.commitMul || strobes.commitDiv;
  assign handlerZero = (handlerReg == '0);
  assign trapAddr    = handlerReg;

  // Restoring divider keeps the partial remainder below the divisor
  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepDiv |=> (hiReg < {1'b0, operand}));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] accIn,
  output logic [WIDTH-1:0] accOut,
  output logic             accWe,
  output logic             busy,
  output logic             trapReq,
  output logic [WIDTH-1:0] trapAddr
);

  mduStrobes_t strobes;
  logic        handlerZero;
  logic        divisorZero;

  assign divisorZero = (wrData == '0);

  mdu_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .divisorZero (divisorZero),
    .handlerZero (handlerZero),
    .strobes     (strobes),
    .busy        (busy),
    .trapReq     (trapReq)
  );

  mdu_datapath #(.WIDTH(WIDTH)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .accIn       (accIn),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .accOut      (accOut),
    .accWe       (accWe),
    .handlerZero (handlerZero),
    .trapAddr    (trapAddr)
  );

  assert_load_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    accWe |-> busy);

endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = 2'd0;
  logic [15:0] rdData;
  logic [15:0] accIn = '0;
  logic [15:0] accOut;
  logic        accWe;
  logic        busy;
  logic        trapReq;
  logic [15:0] trapAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] modelMul = '0;
  logic [15:0] modelDiv = '0;
  logic [15:0] modelHandler = '0;

  always #(CLK_NS/2) clk = ~clk;

  muldiv_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .accIn(accIn), .accOut(accOut),
    .accWe(accWe), .busy(busy), .trapReq(trapReq), .trapAddr(trapAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expResult(input logic [1:0] addr, input logic [15:0] d,
                                            input logic [15:0] a);
    logic [31:0] p;
    if (addr == 2'd0) p = {16'd0, a} * {16'd0, d};
    else if (d == 16'd0) p = {a, 16'd0};
    else p = {a % d, a / d};
    return p; // {high/remainder, low/quotient}
  endfunction

  task automatic readReg(input string req, input logic [1:0] a, input logic [15:0] exp);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  // mode: 0 nothing during busy, 1 ignored start write, 2 handler write
  task automatic runArith(input logic [1:0] addr, input logic [15:0] d,
                          input logic [15:0] a, input int mode, input string req);
    logic [31:0] exp;
    int expCyc;
    int cyc;
    logic [15:0] hv;
    exp = expResult(addr, d, a);
    expCyc = (addr == 2'd1 && d == 16'd0) ? 1 : 17;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = d; accIn = a;
    @(negedge clk);
    check({req, " R6 busy after start"}, busy, 1'b1);
    wrEn = 1'b0;
    accIn = 16'($urandom);
    if (expCyc != 1 && mode == 1) begin
      wrEn = 1'b1; wrAddr = 2'($urandom_range(0, 1)); wrData = 16'($urandom);
    end else if (expCyc != 1 && mode == 2) begin
      hv = 16'($urandom);
      wrEn = 1'b1; wrAddr = 2'd2; wrData = hv; modelHandler = hv;
    end
    cyc = 1;
    while (!accWe && cyc < 25) begin
      @(negedge clk);
      wrEn = 1'b0;
      cyc++;
    end
    check({req, " R6 cycles to result"}, cyc, expCyc);
    check({req, " accumulator result"}, accOut, exp[15:0]);
    @(negedge clk);
    wrEn = 1'b0;
    check({req, " R6 busy drops"}, busy, 1'b0);
    if (addr == 2'd0) modelMul = exp[31:16];
    else modelDiv = exp[31:16];
    readReg({req, " register result"}, addr, exp[31:16]);
    if (mode == 1) begin
      readReg("R7 mul reg after ignored write", 2'd0, modelMul);
      readReg("R7 div reg after ignored write", 2'd1, modelDiv);
    end
    if (mode == 2) readReg("R4 handler written while busy", 2'd2, modelHandler);
  endtask

  task automatic writeHandler(input logic [15:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd2; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    modelHandler = v;
    readReg("R4 handler readback", 2'd2, v);
  endtask

  task automatic trapCase(input logic [15:0] a);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 16'd0; accIn = a;
    @(negedge clk);
    wrEn = 1'b0;
    check("R8 trapReq raised", trapReq, 1'b1);
    check("R8 trapAddr", trapAddr, modelHandler);
    check("R8 busy stays low", busy, 1'b0);
    check("R8 no accumulator load", accWe, 1'b0);
    @(negedge clk);
    check("R8 trapReq one cycle", trapReq, 1'b0);
    check("R8 no late accumulator load", accWe, 1'b0);
    readReg("R8 div reg unchanged", 2'd1, modelDiv);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy at reset", busy, 1'b0);
    check("R1 trapReq at reset", trapReq, 1'b0);
    check("R1 accWe at reset", accWe, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) readReg("R1 register reset value", 2'(i), 16'd0);

    // Directed multiply corners (R2)
    runArith(2'd0, 16'hFFFF, 16'hFFFF, 0, "R2 max*max");
    runArith(2'd0, 16'h1234, 16'h0000, 0, "R2 x*0");
    runArith(2'd0, 16'h0001, 16'hBEEF, 0, "R2 1*x");
    // Directed divide corners (R3)
    runArith(2'd1, 16'h0001, 16'hFFFF, 0, "R3 x/1");
    runArith(2'd1, 16'hFFFF, 16'h1234, 0, "R3 small/large");
    runArith(2'd1, 16'h0007, 16'h0007, 0, "R3 x/x");
    runArith(2'd1, 16'h8000, 16'hFFFF, 0, "R3 top bit divisor");
    // Quiet zero divide (R5)
    runArith(2'd1, 16'h0000, 16'hA5C3, 0, "R5 quiet zero divide");
    runArith(2'd1, 16'h0000, 16'h0000, 0, "R5 zero by zero");
    // Ignored writes while busy (R7), handler write while busy (R4)
    runArith(2'd0, 16'h00FF, 16'h0101, 1, "R7 mul with intrusion");
    runArith(2'd1, 16'h0013, 16'hF00D, 1, "R7 div with intrusion");
    runArith(2'd0, 16'h7777, 16'h3333, 2, "R4 mul with handler write");
    writeHandler(16'h0000);

    // Unused address (R9)
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd3; wrData = 16'hDEAD; accIn = 16'h0055;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9 no start on address 3", busy, 1'b0);
    check("R9 no load on address 3", accWe, 1'b0);
    readReg("R9 address 3 reads zero", 2'd3, 16'd0);
    readReg("R9 mul reg unchanged", 2'd0, modelMul);
    readReg("R9 div reg unchanged", 2'd1, modelDiv);
    readReg("R9 handler unchanged", 2'd2, modelHandler);

    // Trap path (R8)
    writeHandler(16'h4C00);
    trapCase(16'h1357);
    writeHandler(16'hFFFE);
    trapCase(16'h0000);
    writeHandler(16'h0000);
    runArith(2'd1, 16'h0000, 16'h2468, 0, "R5 quiet after handler cleared");

    // Random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0] op;
      logic [15:0] d;
      op = 2'($urandom_range(0, 1));
      d = 16'($urandom);
      if (n % 7 == 0) d = 16'($urandom_range(1, 15));
      runArith(op, d, 16'($urandom), int'($urandom_range(0, 1)),
               (op == 2'd0) ? "R2 random multiply" : "R3 random divide");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule